// File: doc/BRIEF.md
# Indirect Configuration Register Access Port

This block is a bus slave that gives a processor-side register bus access to a bank of 32-bit configuration registers through two small windows. The bus sees only eight bytes of space. The lower four bytes hold a pointer register. Software writes a full word to the pointer. Bit 31 of that word is an enable, and bits [7:2] select one register in the bank. The upper four bytes form the data window. Byte, halfword or word accesses there reach the selected register.

Which register is used comes only from the latched pointer. Which bytes of that register are used comes only from the low two bits of the data-window access address. A sub-word access can therefore land on any aligned byte or halfword of the selected register, even though the pointer stays word aligned.

Write data and read data are right-justified on the bus. Byte lane k of a register is bits [8k+7:8k] and is reached at window offset 4+k. Partial reads are zero-extended. Read data and the error flag are registered.

Top module: `cfg_window_port`

## Requirements
- R1: A word write (size code 2) at window offset 0 stores the whole write-data word in the pointer register. A word read at offset 0 returns the stored pointer word.
- R2: Data-window accesses use offsets 4 to 7. The target register is the one indexed by pointer bits [7:2]. Pointer bits [1:0] and bits [30:8] have no effect on which register is used.
- R3: A word write at offset 4 replaces all four bytes of the selected register with the write data. Bits [8k+7:8k] of the register are the byte seen at offset 4+k.
- R4: A halfword write (size code 1) at offset 4 or 6 replaces only the two bytes at that offset and the next one, taking them from write-data bits [15:0]. The other two bytes keep their values.
- R5: A byte write (size code 0) at offset 4+k replaces only register byte k, taking it from write-data bits [7:0].
- R6: A data-window read returns the addressed byte, halfword or word in the low bits of the read data, with all higher bits zero.
- R7: While pointer bit 31 is 0, data-window reads return 0xFFFF_FFFF, data-window writes change no register, and neither raises the error flag.
- R8: The error flag is raised for one cycle, and no register or pointer changes, for any of these accesses:
  - a halfword at an odd offset;
  - a word at a data-window offset other than 4;
  - size code 3;
  - anything other than a word at offset 0 in the pointer window.

  A rejected read returns 0.
- R9: A write takes effect at the clock edge where it is presented. Read data and the error flag appear in the cycle after the request. Read data holds its value until the next read. The error flag is 0 in cycles that follow no access.
- R10: After reset, the pointer, every register, the read data and the error flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Byte offset inside the 8-byte window pair |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_wdata | input | 32 | Right-justified write data |
| bus_rdata | output | 32 | Registered, right-justified read data |
| bus_err | output | 1 | Registered rejection flag |

## Verification
Most internal faults show up at the ports within one or two accesses.
- A wrong pointer value or a wrong index slice sends a later data access to the wrong register. The next read returns that other register's contents, or all ones if the enable bit was lost.
- A wrong byte-enable mask or a wrong write shift corrupts bytes that should have been kept. This appears on the first word read of the same register.
- A wrong alignment decision appears in the very next cycle, either as a bad error flag or as a missing error flag.

A reference model in the bench follows every access cycle by cycle and compares both outputs after each one.

// File: rtl/cfg_window_pkg.sv
// Package: shared encodings for the indirect configuration access port.
// Assumes a 32-bit register bank with four byte lanes.
package cfg_window_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / 8;
    localparam int ENABLE_BIT = 31;
endpackage

// File: rtl/cfg_ptr_reg.sv
// Module: pointer register holding the latched configuration address word.
// Assumes the caller has already checked alignment before raising load.
module cfg_ptr_reg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    output logic [WORD_W-1:0] ptr_q
);
    // Store the pointer word on an accepted pointer-window write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (load)
            ptr_q <= load_val;
    end
endmodule

// File: rtl/cfg_lane_steer.sv
// Module: combinational lane steering for data-window accesses.
// Checks alignment, builds the byte-enable mask and the shifted write data,
// and extracts right-justified, zero-extended read data from a register word.
// Assumes lane k maps to bits [8k+7:8k] of the register.
module cfg_lane_steer
    import cfg_window_pkg::*;
#(
    parameter int LANES = 4,
    localparam int WORD_W = LANES * 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] reg_word,
    output logic              aligned,
    output logic [LANES-1:0]  byte_en,
    output logic [WORD_W-1:0] wdata_sh,
    output logic [WORD_W-1:0] rdata_ext
);
    acc_size_e sz;
    logic [LANES-1:0]  base_mask;
    logic [WORD_W-1:0] rd_sh;
    logic [WORD_W-1:0] bit_mask;

    assign sz = acc_size_e'(size);

    // Decide alignment and the unshifted lane mask from the access size.
    always_comb begin
        unique case (sz)
            SZ_BYTE: begin aligned = 1'b1;          base_mask = LANES'(4'b0001); end
            SZ_HALF: begin aligned = (off[0] == 1'b0); base_mask = LANES'(4'b0011); end
            SZ_WORD: begin aligned = (off == '0);    base_mask = '1;              end
            default: begin aligned = 1'b0;          base_mask = '0;              end
        endcase
    end

    assign byte_en  = base_mask << off;
    assign wdata_sh = wdata << {off, 3'b000};
    assign rd_sh    = reg_word >> {off, 3'b000};

    // Expand the lane mask to bits so the read result is zero-extended.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_mask
            assign bit_mask[g*8 +: 8] = {8{base_mask[g]}};
        end
    endgenerate

    assign rdata_ext = rd_sh & bit_mask;
endmodule

// File: rtl/cfg_reg_bank.sv
// Module: bank of configuration registers with per-byte write enables.
// Each byte lane is stored separately. Reads are combinational by index.
// Assumes at most one write per cycle.
module cfg_reg_bank #(
    parameter int NUM_REGS = 64,
    parameter int LANES    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int WORD_W  = LANES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  byte_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_word
);
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [7:0] lane_mem [NUM_REGS];

            // Clear the lane on reset; otherwise update the selected byte.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < NUM_REGS; i++)
                        lane_mem[i] <= '0;
                end else if (wr_en && byte_en[l]) begin
                    lane_mem[idx] <= wdata[l*8 +: 8];
                end
            end

            assign rd_word[l*8 +: 8] = lane_mem[idx];
        end
    endgenerate
endmodule

// File: rtl/cfg_window_port.sv
// Module: top of the indirect configuration access port.
// Offsets 0..3 form the pointer window and offsets 4..7 the data window.
// Assumes single-cycle requests and registers read data and the error flag.
module cfg_window_port
    import cfg_window_pkg::*;
#(
    parameter int NUM_REGS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [1:0]  bus_size,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_err
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic        is_data;
    logic        ptr_ok;
    logic        lane_ok;
    logic        acc_ok;
    logic        enabled;
    logic        ptr_load;
    logic        bank_wr;
    logic [31:0] ptr_q;
    logic [3:0]  byte_en;
    logic [31:0] wdata_sh;
    logic [31:0] rd_word;
    logic [31:0] rd_ext;
    logic [31:0] rdata_d;

    assign is_data  = bus_addr[2];
    assign ptr_ok   = (acc_size_e'(bus_size) == SZ_WORD) && (bus_addr[1:0] == 2'b00);
    assign acc_ok   = is_data ? lane_ok : ptr_ok;
    assign enabled  = ptr_q[ENABLE_BIT];
    assign ptr_load = bus_sel && bus_we && !is_data && ptr_ok;
    assign bank_wr  = bus_sel && bus_we && is_data && lane_ok && enabled;

    cfg_ptr_reg #(.WORD_W(32)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (bus_wdata),
        .ptr_q    (ptr_q)
    );

    cfg_lane_steer #(.LANES(LANES)) u_steer (
        .off       (bus_addr[1:0]),
        .size      (bus_size),
        .wdata     (bus_wdata),
        .reg_word  (rd_word),
        .aligned   (lane_ok),
        .byte_en   (byte_en),
        .wdata_sh  (wdata_sh),
        .rdata_ext (rd_ext)
    );

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .LANES(LANES)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_wr),
        .idx     (ptr_q[IDX_W+1:2]),
        .byte_en (byte_en),
        .wdata   (wdata_sh),
        .rd_word (rd_word)
    );

    // Choose the read result: rejected, pointer readback, disabled or register data.
    always_comb begin
        if (!acc_ok)
            rdata_d = '0;
        else if (!is_data)
            rdata_d = ptr_q;
        else if (!enabled)
            rdata_d = '1;
        else
            rdata_d = rd_ext;
    end

    // Register the read data on reads and the error flag on every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            if (bus_sel && !bus_we)
                bus_rdata <= rdata_d;
            bus_err <= bus_sel && !acc_ok;
        end
    end
endmodule

// File: rtl/cfg_window_checker.sv
// Module: assertion checker for cfg_window_port, attached with bind.
// Assumes it sees the top-level ports plus the latched pointer word.
module cfg_window_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [2:0]  bus_addr,
    input logic [1:0]  bus_size,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        bus_err,
    input logic [31:0] ptr_q
);
    a_r1_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 3'd0 && bus_size == 2'd2) |=> (ptr_q == $past(bus_wdata)));

    a_r1_ptr_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == 3'd0 && bus_size == 2'd2) |=> (bus_rdata == $past(ptr_q)));

    a_r7_disabled_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr[2] && !ptr_q[31] && bus_size == 2'd0) |=> (bus_rdata == 32'hFFFF_FFFF && !bus_err));

    a_r8_odd_half_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_size == 2'd1 && bus_addr[0]) |=> bus_err);

    a_r8_ptr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_addr[2] && bus_size != 2'd2) |=> ($stable(ptr_q) && bus_err));

    a_r9_idle_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bus_err);

    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> $stable(bus_rdata));
endmodule

bind cfg_window_port cfg_window_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .ptr_q     (ptr_q)
);

// File: tb/tb_cfg_window_port.sv
// Bench: behavioural reference model compared with the design after every cycle.
module tb_cfg_window_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_regs [64];
    logic [31:0] m_ptr;
    logic [31:0] exp_rdata;
    logic        exp_err;

    always #2 clk = ~clk;

    cfg_window_port dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    task automatic check(input string req);
        n_chk++;
        if (bus_rdata !== exp_rdata || bus_err !== exp_err) begin
            n_fail++;
            $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                     req, bus_rdata, bus_err, exp_rdata, exp_err);
        end
    endtask

    // One access cycle: update the model, drive at negedge, check one cycle later.
    task automatic access(input bit we, input int off, input int size,
                          input logic [31:0] wd, input string req);
        int n;
        int d;
        int idx;
        bit ok;
        logic [31:0] v;
        n = (size == 0) ? 1 : (size == 1) ? 2 : (size == 2) ? 4 : 0;
        if (off >= 4) begin
            d  = off - 4;
            ok = (n != 0) && (d % n == 0);
        end else begin
            d  = 0;
            ok = (size == 2) && (off == 0);
        end
        idx = (m_ptr >> 2) & 63;
        exp_err = !ok;
        if (!we) begin
            if (!ok)               exp_rdata = 32'h0;
            else if (off < 4)      exp_rdata = m_ptr;
            else if (!m_ptr[31])   exp_rdata = 32'hFFFF_FFFF;
            else begin
                v = 32'h0;
                for (int i = 0; i < n; i++)
                    v[8*i +: 8] = m_regs[idx][8*(d+i) +: 8];
                exp_rdata = v;
            end
        end
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = 3'(off);
        bus_size = 2'(size); bus_wdata = wd;
        @(negedge clk);
        bus_sel = 1'b0;
        if (we && ok) begin
            if (off < 4) m_ptr = wd;
            else if (m_ptr[31]) begin
                for (int i = 0; i < n; i++)
                    m_regs[idx][8*(d+i) +: 8] = wd[8*i +: 8];
            end
        end
        check(req);
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        exp_err = 1'b0;
        check(req);
    endtask

    task automatic wr(input int off, input int size, input logic [31:0] wd, input string req);
        access(1'b1, off, size, wd, req);
    endtask

    task automatic rd(input int off, input int size, input string req);
        access(1'b0, off, size, 32'h0, req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: rdata=%h err=%b expected run to complete", bus_rdata, bus_err);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m_regs[i] = 32'h0;
        m_ptr = 32'h0; exp_rdata = 32'h0; exp_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset outputs");
        rd(0, 2, "R10 pointer zero after reset");

        // R7: disabled pointer
        rd(4, 2, "R7 disabled word read all ones");
        rd(5, 0, "R7 disabled byte read all ones");
        wr(4, 2, 32'h1234_5678, "R7 disabled write ignored");
        wr(0, 2, 32'h8000_0000, "R1 enable reg 0");
        rd(4, 2, "R7 reg 0 untouched by disabled write");

        // R1: pointer latch and readback
        wr(0, 2, 32'h8000_00A8, "R1 pointer write");
        rd(0, 2, "R1 pointer readback");

        // R3: word write and readback
        wr(4, 2, 32'hFFFF_FFFF, "R3 word fill");
        wr(4, 2, 32'hAABB_CCDD, "R3 word write");
        rd(4, 2, "R3 word readback");
        for (int k = 0; k < 4; k++) rd(4 + k, 0, "R6 byte lane read");
        rd(4, 1, "R6 low half read");
        rd(6, 1, "R6 high half read");

        // R4: halfword write
        wr(4, 2, 32'hFFFF_FFFF, "R4 refill");
        wr(6, 1, 32'hAABB_CCDD, "R4 half write upper");
        rd(4, 2, "R4 only upper half changed");
        wr(4, 1, 32'h0000_1122, "R4 half write lower");
        rd(4, 2, "R4 lower half changed");

        // R5: byte write
        wr(4, 2, 32'hFFFF_FFFF, "R5 refill");
        wr(6, 0, 32'hAABB_CCDD, "R5 byte write lane 2");
        rd(4, 2, "R5 only lane 2 changed");
        wr(7, 0, 32'h0000_0042, "R5 byte write lane 3");
        rd(4, 2, "R5 lane 3 changed");

        // R2: pointer bits [1:0] and [30:8] ignored for selection
        wr(0, 2, 32'h8000_00AB, "R2 low bits set");
        rd(4, 2, "R2 low bits ignored");
        wr(0, 2, 32'hA5A5_A1A8, "R2 high bits set");
        rd(4, 2, "R2 high bits ignored");
        wr(0, 2, 32'h8000_00AC, "R2 neighbour select");
        wr(4, 2, 32'h0BAD_F00D, "R2 neighbour write");
        wr(0, 2, 32'h8000_00A8, "R2 back to A8");
        rd(4, 2, "R2 neighbour write kept apart");

        // R8: rejected accesses
        wr(5, 1, 32'h0000_0000, "R8 odd half write");
        wr(6, 2, 32'h0000_0000, "R8 word at offset 6");
        wr(4, 3, 32'h0000_0000, "R8 reserved size");
        rd(7, 1, "R8 odd half read returns zero");
        wr(0, 0, 32'h0000_0000, "R8 byte to pointer");
        wr(2, 2, 32'h0000_0000, "R8 word at pointer offset 2");
        wr(1, 1, 32'h0000_0000, "R8 odd half to pointer");
        rd(0, 2, "R8 pointer unchanged");
        rd(4, 2, "R8 register unchanged");

        // R9: idle holds rdata, error cleared
        idle("R9 idle after read");
        wr(4, 0, 32'h0000_0077, "R9 write keeps rdata");
        idle("R9 idle holds rdata");
        rd(4, 0, "R9 write visible next cycle");

        // R2/R3: all 64 registers distinct
        for (int r = 0; r < 64; r++) begin
            wr(0, 2, 32'h8000_0000 | (r << 2), "R2 select reg");
            wr(4, 2, 32'h5A00_0000 ^ (r * 32'h0101_0101), "R3 fill reg");
        end
        for (int r = 0; r < 64; r += 9) begin
            wr(0, 2, 32'h8000_0000 | (r << 2), "R2 reselect reg");
            rd(4, 2, "R2 distinct register readback");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule